// File: doc/BRIEF.md
# Programmable Dual-Modulus Frequency Divider

This block divides a fast oscillator clock by a programmable integer N = 32·M + S and emits one single-cycle pulse per N input cycles, suitable as the feedback input of a phase-frequency detector. Internally a prescaler counts either 32 or 33 input cycles per prescaler cycle. A main counter counts M prescaler cycles per output period. During the first S of those cycles a swallow comparison holds the prescaler in its divide-by-33 mode, and during the remaining M − S cycles it uses divide-by-32.

The main modulus M is chosen by a 2-bit code. The swallow count S is a 5-bit binary value. Both are sampled only at an output-period boundary, or while reset is held, so a reprogramming in the middle of a period never shortens or stretches the period that is already running. A typical use is stepping through a radio channel plan: the code selects M = 34 and S is lowered by one per channel, which moves the output frequency in equal steps.

Top module: `pswallow_divider`

## Requirements
- R1: While `rst` is high at a rising edge, `div_pulse` is low after that edge. After reset is released, the first pulse appears after the N-th rising edge with `rst` low. N here uses the settings sampled at the last reset edge.
- R2: `main_sel` picks the main modulus as follows: 2'b00 gives M = 31, 2'b01 gives 32, 2'b10 gives 33 and 2'b11 gives 34.
- R3: `swallow` is an unsigned binary count from 0 to 31. Bit 0 is the least significant bit, with weight 1, and bit 4 has weight 16. S adds S input cycles to the period.
- R4: The spacing between consecutive pulses is exactly N = 32·M + S input cycles. This holds across the whole range, from 992 (M = 31, S = 0) to 1119 (M = 34, S = 31).
- R5: Each pulse on `div_pulse` is high for exactly one input cycle.
- R6: A change of `main_sel` or `swallow` in the middle of a period leaves that period's length unchanged. The new values are sampled at the rising edge that ends the period, and they set the length of the following period.
- R7: With S = 0 the divider runs all M prescaler cycles in divide-by-32 mode, giving a period of exactly 32·M.
- R8: Within each period the prescaler spends the first S prescaler cycles in divide-by-33 mode and the remaining M − S cycles in divide-by-32 mode. Its mode changes only at a prescaler-cycle boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock being divided |
| rst | input | 1 | Synchronous reset, active high |
| main_sel | input | 2 | Main modulus code (M = 31 + code) |
| swallow | input | 5 | Swallow count S, binary, bit 0 least significant |
| div_pulse | output | 1 | One-cycle pulse per N input cycles |

## Verification
The output pulse is registered. A period that begins after rising edge k ends with the pulse visible right after edge k + N, where N is computed from the settings present at edge k. The bench keeps its own count of rising edges since the last boundary and recomputes N from the inputs sampled at each boundary. It compares `div_pulse` with this model on every falling edge, so a pulse that comes one cycle early or late is caught. Stimulus changes only on falling edges. Mid-period changes therefore fall wholly inside one period, and the bench expects their effect exactly one boundary later.

// File: rtl/pswallow_pkg.sv
package pswallow_pkg;

   typedef enum logic {
      PS_DIV_BASE  = 1'b0,
      PS_DIV_PLUS1 = 1'b1
   } ps_mode_e;

   // True when every swallow count fits inside the smallest main modulus.
   function automatic bit swallow_fits(input int main_base, input int swl_w);
      return ((1 << swl_w) - 1) <= main_base;
   endfunction

endpackage

// File: rtl/dm_prescaler.sv
module dm_prescaler
   import pswallow_pkg::*;
#(
   parameter int PRE_W = 5
) (
   input  logic     clk,
   input  logic     rst,
   input  ps_mode_e mode,
   output logic     tick
);
   localparam int CNT_W   = PRE_W + 1;
   localparam int LAST_LO = (1 << PRE_W) - 1;
   localparam int LAST_HI = (1 << PRE_W);

   logic [CNT_W-1:0] pc;
   logic [CNT_W-1:0] last;

   always_comb begin
      last = (mode == PS_DIV_PLUS1) ? CNT_W'(LAST_HI) : CNT_W'(LAST_LO);
      tick = (pc == last);
   end

   always_ff @(posedge clk) begin
      if (rst)       pc <= '0;
      else if (tick) pc <= '0;
      else           pc <= pc + CNT_W'(1);
   end

   // R8
   pc_range_chk: assert property (@(posedge clk) disable iff (rst)
      pc <= CNT_W'(LAST_HI));

   // R8
   mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !tick |=> $stable(mode));

endmodule

// File: rtl/ratio_latch.sv
module ratio_latch #(
   parameter int MAIN_SEL_W = 2,
   parameter int SWL_W      = 5,
   parameter int MAIN_BASE  = 31,
   parameter int MC_W       = 6
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  load,
   input  logic [MAIN_SEL_W-1:0] main_sel,
   input  logic [SWL_W-1:0]      swallow,
   output logic [MC_W-1:0]       cur_m,
   output logic [SWL_W-1:0]      cur_s
);
   always_ff @(posedge clk) begin
      if (rst || load) begin
         cur_m <= MC_W'(MAIN_BASE) + MC_W'(main_sel);
         cur_s <= swallow;
      end
   end

   // R6
   cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !load |=> ($stable(cur_m) && $stable(cur_s)));

endmodule

// File: rtl/modulus_ctl.sv
module modulus_ctl
   import pswallow_pkg::*;
#(
   parameter int MC_W    = 6,
   parameter int SWL_W   = 5,
   parameter bit REG_OUT = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tick,
   input  logic [MC_W-1:0]  cur_m,
   input  logic [SWL_W-1:0] cur_s,
   output ps_mode_e         mode,
   output logic             boundary,
   output logic             pulse
);
   logic [MC_W-1:0] mc;

   always_comb begin
      mode     = (mc < MC_W'(cur_s)) ? PS_DIV_PLUS1 : PS_DIV_BASE;
      boundary = tick && (mc == (cur_m - MC_W'(1)));
   end

   always_ff @(posedge clk) begin
      if (rst)           mc <= '0;
      else if (boundary) mc <= '0;
      else if (tick)     mc <= mc + MC_W'(1);
   end

   generate
      if (REG_OUT) begin : g_reg_out
         logic pulse_q;
         always_ff @(posedge clk) begin
            if (rst) pulse_q <= 1'b0;
            else     pulse_q <= boundary;
         end
         assign pulse = pulse_q;
      end else begin : g_comb_out
         assign pulse = boundary && !rst;
      end
   endgenerate

   // R4
   mc_range_chk: assert property (@(posedge clk) disable iff (rst)
      mc < cur_m);

   // R5
   pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
      pulse |=> !pulse);

   // R8
   mode_drop_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(mode == PS_DIV_PLUS1) |-> $past(tick));

endmodule

// File: rtl/pswallow_divider.sv
module pswallow_divider
   import pswallow_pkg::*;
#(
   parameter int PRE_W      = 5,
   parameter int MAIN_SEL_W = 2,
   parameter int MAIN_BASE  = 31,
   parameter int SWL_W      = 5,
   parameter bit REG_OUT    = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic [MAIN_SEL_W-1:0] main_sel,
   input  logic [SWL_W-1:0]      swallow,
   output logic                  div_pulse
);
   localparam int MAIN_MAX = MAIN_BASE + (1 << MAIN_SEL_W) - 1;
   localparam int MC_W     = $clog2(MAIN_MAX + 1);

   if (!swallow_fits(MAIN_BASE, SWL_W)) begin : g_bad_swallow
      $error("swallow range exceeds smallest main modulus");
   end
   if (MAIN_BASE < 2) begin : g_bad_base
      $error("main modulus base must be at least 2");
   end
   if (PRE_W < 1) begin : g_bad_pre
      $error("prescaler width must be positive");
   end

   ps_mode_e         mode;
   logic             tick;
   logic             boundary;
   logic [MC_W-1:0]  cur_m;
   logic [SWL_W-1:0] cur_s;

   dm_prescaler #(.PRE_W(PRE_W)) u_pre (
      .clk  (clk),
      .rst  (rst),
      .mode (mode),
      .tick (tick)
   );

   ratio_latch #(
      .MAIN_SEL_W (MAIN_SEL_W),
      .SWL_W      (SWL_W),
      .MAIN_BASE  (MAIN_BASE),
      .MC_W       (MC_W)
   ) u_latch (
      .clk      (clk),
      .rst      (rst),
      .load     (boundary),
      .main_sel (main_sel),
      .swallow  (swallow),
      .cur_m    (cur_m),
      .cur_s    (cur_s)
   );

   modulus_ctl #(
      .MC_W    (MC_W),
      .SWL_W   (SWL_W),
      .REG_OUT (REG_OUT)
   ) u_ctl (
      .clk      (clk),
      .rst      (rst),
      .tick     (tick),
      .cur_m    (cur_m),
      .cur_s    (cur_s),
      .mode     (mode),
      .boundary (boundary),
      .pulse    (div_pulse)
   );

   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      rst |=> !div_pulse);

endmodule

// File: tb/pswallow_divider_tb.sv
module pswallow_divider_tb;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 190000;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [1:0] main_sel = 2'd1;
   logic [4:0] swallow  = 5'd0;
   logic       div_pulse;

   int    checks = 0;
   int    fails  = 0;
   string tag    = "R1";
   bit    done   = 1'b0;

   // model state
   int cnt = 0;
   int n_lat = 1024;
   int done_n = 0;
   int edge_cnt = 0;
   bit exp_p = 1'b0;
   bit started = 1'b0;
   int last_act = 0;

   pswallow_divider u_dut (
      .clk       (clk),
      .rst       (rst),
      .main_sel  (main_sel),
      .swallow   (swallow),
      .div_pulse (div_pulse)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // R2: code c gives M = 31 + c; R3: S binary; R4: N = 32*M + S
   function automatic int exp_ratio(input logic [1:0] s, input logic [4:0] w);
      return 32 * (31 + int'(s)) + int'(w);
   endfunction

   always @(posedge clk) begin
      started = 1'b1;
      if (rst) begin
         cnt = 0;
         edge_cnt = 0;
         n_lat = exp_ratio(main_sel, swallow);
         exp_p = 1'b0;
      end else begin
         cnt++;
         edge_cnt++;
         if (cnt == n_lat) begin
            exp_p  = 1'b1;
            done_n = n_lat;
            cnt    = 0;
            n_lat  = exp_ratio(main_sel, swallow);
         end else begin
            exp_p = 1'b0;
         end
      end
   end

   always @(negedge clk) begin
      if (started && !done) begin
         if (rst) last_act = 0;
         if (exp_p || div_pulse !== 1'b0) begin
            checks++;
            if (div_pulse !== exp_p) begin
               fails++;
               $display("FAIL %s R5 pulse at edge %0d: actual=%b expected=%b",
                        tag, edge_cnt, div_pulse, exp_p);
            end
         end
         if (div_pulse === 1'b1 && exp_p) begin
            checks++;
            if (edge_cnt - last_act != done_n) begin
               fails++;
               $display("FAIL %s R4 period: actual=%0d expected=%0d",
                        tag, edge_cnt - last_act, done_n);
            end
            last_act = edge_cnt;
         end
      end
   end

   task automatic wait_pulses(input int k);
      for (int i = 0; i < k; i++) begin
         do @(negedge clk); while (!exp_p);
      end
   endtask

   task automatic set_cfg(input logic [1:0] s, input logic [4:0] w);
      main_sel = s;
      swallow  = w;
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      int r;
      r = $urandom(32'd2718);
      repeat (4) @(negedge clk);
      // R1: low during reset
      checks++;
      if (div_pulse !== 1'b0) begin
         fails++;
         $display("FAIL R1 reset: actual=%b expected=0", div_pulse);
      end
      rst = 1'b0;
      tag = "R1";
      wait_pulses(1);

      // R2 and R7: each code with S = 0
      for (int c = 0; c < 4; c++) begin
         tag = "R2 R7";
         set_cfg(2'(c), 5'd0);
         wait_pulses(2);
      end

      // R3: single bit weights
      for (int b = 0; b < 5; b++) begin
         tag = "R3";
         set_cfg(2'd2, 5'(1 << b));
         wait_pulses(2);
      end

      // R4: extremes 992 and 1119
      tag = "R4";
      set_cfg(2'd0, 5'd0);
      wait_pulses(2);
      set_cfg(2'd3, 5'd31);
      wait_pulses(2);

      // R8: channel stepping M = 34, S = 10 down to 1
      tag = "R8";
      for (int s = 10; s >= 1; s--) begin
         set_cfg(2'd3, 5'(s));
         wait_pulses(1);
      end
      wait_pulses(1);

      // R6: mid-period change
      tag = "R6";
      set_cfg(2'd3, 5'd31);
      wait_pulses(2);
      repeat (500) @(negedge clk);
      set_cfg(2'd0, 5'd0);
      wait_pulses(2);

      // R6: random changes at random times
      for (int i = 0; i < 40; i++) begin
         tag = "R6";
         repeat ($urandom_range(0, 1200)) @(negedge clk);
         set_cfg(2'($urandom_range(0, 3)), 5'($urandom_range(0, 31)));
      end
      wait_pulses(2);

      // R1: reset in mid-period, then first period from release
      repeat (300) @(negedge clk);
      tag = "R1";
      rst = 1'b1;
      set_cfg(2'd1, 5'd7);
      repeat (3) @(negedge clk);
      checks++;
      if (div_pulse !== 1'b0) begin
         fails++;
         $display("FAIL R1 mid reset: actual=%b expected=0", div_pulse);
      end
      rst = 1'b0;
      wait_pulses(2);

      finish_run();
   end

endmodule